// File: doc/BRIEF.md
# Three-Channel Shared-Period PWM Timer

This block produces three pulse-width-modulated outputs that share one period. A single up-counter runs while the count enable is high. It is compared against one period value and against a separate duty value for each channel. When the counter reaches the period value, every output is driven to its own programmed start level, and the counter returns to zero on that same edge. When the counter reaches a channel's duty value, that channel's output is driven to the opposite of its start level. The start level of each channel is set by one level bit, so each channel can produce either an active-high or an active-low pulse.

Software or a neighbouring controller programs the period, the three duty values and the level bits through a plain synchronous write port. A write changes the compare source at the next edge, because the registers are not double-buffered. A one-cycle flag shows each period match, so a system can line other events up with the PWM frame. The block carries no data stream, so every pin is a plain control or status pin and there is no valid/ready handshake.

Top module: `pwm3_timer`

## Requirements
- R1: In reset the counter is zero, the period register holds PRD_RST, every duty register is zero, the level bits hold RST_LVL, each `pwm_out[i]` is the inverse of `RST_LVL[i]`, and `prd_flag` is 0.
- R2: On each edge with `cnt_en` high, the counter steps up by one, unless it equals the period. With `cnt_en` low, the counter holds, no compare fires and no output changes.
- R3: On an enabled edge where the counter equals the period register, the counter becomes zero and `prd_flag` is 1 for the following cycle only. A period of zero therefore raises the flag on every enabled cycle.
- R4: On a period match, a channel whose level bit is 1 (and whose duty differs from the period) goes high. On an enabled edge where the counter equals its duty value, it goes low.
- R5: On a period match, a channel whose level bit is 0 (and whose duty differs from the period) goes low. On its own duty match, it goes high.
- R6: A channel whose duty register equals the period register keeps its output level on every edge.
- R7: A channel whose duty value is greater than the period is never driven by a duty match. After each period match it stays at its start level.
- R8: A write with `wr_en` high stores `wr_data` at the next edge and takes part in the compare from the following edge on. The address map is: 0 = period, 1 + i = duty of channel i, N_CH + 1 = level bits in `wr_data[N_CH-1:0]`. Writes to any other address change nothing.
- R9: If the period is lowered below the present count, the counter keeps rising, wraps from all ones to zero, and then matches the new period.
- R10: Each channel acts only on its own duty value and level bit. Other channels with different settings do not change its output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable; the counter and all compares act only while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select (see R8) |
| wr_data | input | CNT_W | Write value |
| pwm_out | output | N_CH | PWM outputs, bit i is channel i |
| prd_flag | output | 1 | One-cycle pulse after each period match |

## Verification
The bench builds the block with an 8-bit counter, three channels and a reset level pattern of 101, so both polarities are live from reset onward. With only 256 count values, the counter wraps from all ones to zero within a few hundred cycles after the period is lowered below the count. A reset period of 255 means the first frame after reset also ends at that wrap point. Short periods of 9, 4 and 0 show back-to-back matches, duty values on both sides of the period, and a flag that stays high on every enabled cycle.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  // Action a channel takes on a given clock edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,  // keep current level
    ACT_START = 2'd1,  // period match: drive programmed start level
    ACT_FLIP  = 2'd2   // duty match: drive the opposite level
  } chan_act_e;

  // Fixed register offsets; duty offsets follow DUTY_BASE + channel
  localparam int unsigned PERIOD_OFS = 0;
  localparam int unsigned DUTY_BASE  = 1;

endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned N_CH    = 3,
  parameter int unsigned ADDR_W  = 3,
  parameter logic [CNT_W-1:0] PRD_RST = '1,
  parameter logic [N_CH-1:0]  RST_LVL = '1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [CNT_W-1:0]             wr_data,
  output logic [CNT_W-1:0]             prd_q,
  output logic [N_CH-1:0][CNT_W-1:0]   duty_q,
  output logic [N_CH-1:0]              lvl_q
);
  import pwm3_pkg::*;

  localparam logic [ADDR_W-1:0] LVL_OFS = ADDR_W'(DUTY_BASE + N_CH);
  localparam logic [ADDR_W-1:0] PRD_A   = ADDR_W'(PERIOD_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_q <= PRD_RST;
      lvl_q <= RST_LVL;
    end else if (wr_en) begin
      if (wr_addr == PRD_A)   prd_q <= wr_data;
      if (wr_addr == LVL_OFS) lvl_q <= wr_data[N_CH-1:0];
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_duty
    localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(DUTY_BASE + g);
    always_ff @(posedge clk) begin
      if (!rst_n)                          duty_q[g] <= '0;
      else if (wr_en && wr_addr == MY_OFS) duty_q[g] <= wr_data;
    end
  end

endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] prd_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             prd_hit,
  output logic             prd_flag
);

  // Period compare only counts while the counter is running
  assign prd_hit = cnt_en && (cnt_q == prd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      prd_flag <= 1'b0;
    end else begin
      prd_flag <= prd_hit;
      if (prd_hit)     cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm3_chan.sv
module pwm3_chan #(
  parameter int unsigned CNT_W   = 16,
  parameter logic        LVL_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             prd_hit,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] prd_q,
  input  logic [CNT_W-1:0] duty_q,
  input  logic             lvl,
  output logic             pwm_q
);
  import pwm3_pkg::*;

  chan_act_e act;

  always_comb begin
    if (duty_q == prd_q)                   act = ACT_HOLD;
    else if (prd_hit)                      act = ACT_START;
    else if (cnt_en && cnt_q == duty_q)    act = ACT_FLIP;
    else                                   act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q <= ~LVL_RST;
    end else begin
      unique case (act)
        ACT_START: pwm_q <= lvl;
        ACT_FLIP:  pwm_q <= ~lvl;
        default:   pwm_q <= pwm_q;
      endcase
    end
  end

endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned N_CH    = 3,
  parameter int unsigned ADDR_W  = $clog2(N_CH + 2),
  parameter logic [CNT_W-1:0] PRD_RST = '1,
  parameter logic [N_CH-1:0]  RST_LVL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [N_CH-1:0]   pwm_out,
  output logic              prd_flag
);

  logic [CNT_W-1:0]           prd_q;
  logic [N_CH-1:0][CNT_W-1:0] duty_q;
  logic [N_CH-1:0]            lvl_q;
  logic [CNT_W-1:0]           cnt_q;
  logic                       prd_hit;

  pwm3_regs #(
    .CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W),
    .PRD_RST(PRD_RST), .RST_LVL(RST_LVL)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prd_q(prd_q), .duty_q(duty_q), .lvl_q(lvl_q)
  );

  pwm3_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .prd_q(prd_q),
    .cnt_q(cnt_q), .prd_hit(prd_hit), .prd_flag(prd_flag)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    pwm3_chan #(.CNT_W(CNT_W), .LVL_RST(RST_LVL[g])) i_chan (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .prd_hit(prd_hit),
      .cnt_q(cnt_q), .prd_q(prd_q), .duty_q(duty_q[g]), .lvl(lvl_q[g]),
      .pwm_q(pwm_out[g])
    );
  end

endmodule

// File: rtl/pwm3_timer_chk.sv
module pwm3_timer_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cnt_en,
  input logic [CNT_W-1:0]           cnt_q,
  input logic [CNT_W-1:0]           prd_q,
  input logic [N_CH-1:0][CNT_W-1:0] duty_q,
  input logic [N_CH-1:0]            lvl_q,
  input logic [N_CH-1:0]            pwm_out,
  input logic                       prd_flag
);

  // R3: the flag follows the edge that cleared the counter
  a_r3_clear_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    prd_flag |-> cnt_q == '0);

  // R3: a nonzero period yields a single-cycle flag
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_flag && prd_q != '0) |=> !prd_flag);

  // R2: disabled counter holds and raises no flag
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(cnt_q) && !prd_flag));

  // R2: enabled counter below the period steps by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt_q != prd_q) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    // R6: equal duty and period freezes the channel
    a_r6_equal_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(duty_q[g] == prd_q)) |-> $stable(pwm_out[g]));

    // R4 / R5: period match drives the programmed start level
    a_r4_start_level: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cnt_en && cnt_q == prd_q && duty_q[g] != prd_q))
        |-> pwm_out[g] == $past(lvl_q[g]));

    // R2: no output movement while counting is off
    a_r2_out_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!cnt_en)) |-> $stable(pwm_out[g]));
  end

endmodule

bind pwm3_timer pwm3_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) i_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_q(cnt_q), .prd_q(prd_q),
  .duty_q(duty_q), .lvl_q(lvl_q), .pwm_out(pwm_out), .prd_flag(prd_flag)
);

// File: tb/test_pwm3_timer.sv
module test_pwm3_timer;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int NC = 3;
  localparam int AW = 3;
  localparam logic [W-1:0]  P_RST = 8'hFF;
  localparam logic [NC-1:0] L_RST = 3'b101;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [NC-1:0] pwm_out;
  logic          prd_flag;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [NC-1:0] out;
    logic          flag;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // bench-side model state
  logic [W-1:0]  m_cnt, m_prd, m_duty[NC];
  logic [NC-1:0] m_lvl, m_out;
  string         cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm3_timer #(.CNT_W(W), .N_CH(NC), .PRD_RST(P_RST), .RST_LVL(L_RST)) i_pwm3_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .prd_flag(prd_flag)
  );

  task automatic check(input string tag, input logic [NC-1:0] act_o, input logic act_f,
                       input logic [NC-1:0] exp_o, input logic exp_f);
    checks++;
    if (act_o !== exp_o || act_f !== exp_f) begin
      fails++;
      $display("FAIL %s: out=%b flag=%b expected out=%b flag=%b", tag, act_o, act_f, exp_o, exp_f);
    end
  endtask

  // Driver: called at a negedge; drives one cycle and queues its expected result
  task automatic step(input logic en, input logic we, input int addr, input int data);
    exp_t e;
    logic hit;
    cnt_en  = en;
    wr_en   = we;
    wr_addr = AW'(addr);
    wr_data = W'(data);
    hit = en && (m_cnt == m_prd);
    for (int i = 0; i < NC; i++) begin
      if (m_duty[i] == m_prd)                  m_out[i] = m_out[i];
      else if (hit)                            m_out[i] = m_lvl[i];
      else if (en && m_cnt == m_duty[i])       m_out[i] = ~m_lvl[i];
    end
    if (hit)     m_cnt = '0;
    else if (en) m_cnt = m_cnt + 1'b1;
    if (we) begin
      if (addr == 0) m_prd = W'(data);
      for (int i = 0; i < NC; i++) if (addr == i + 1) m_duty[i] = W'(data);
      if (addr == NC + 1) m_lvl = NC'(data);
    end
    e.out = m_out; e.flag = hit; e.tag = cur_tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic en);
    for (int i = 0; i < n; i++) step(en, 1'b0, 0, 0);
  endtask

  task automatic wr(input int addr, input int data);
    step(1'b0, 1'b1, addr, data);
  endtask

  // Monitor: pops one expected item after each edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, pwm_out, prd_flag, e.out, e.flag);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: out=%b flag=%b expected run to finish", pwm_out, prd_flag);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_cnt = '0; m_prd = P_RST; m_lvl = L_RST; m_out = ~L_RST;
    for (int i = 0; i < NC; i++) m_duty[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 reset", pwm_out, prd_flag, ~L_RST, 1'b0);
    rst_n = 1'b1;
    #1 check("R1 after release", pwm_out, prd_flag, ~L_RST, 1'b0);
    @(negedge clk);

    cur_tag = "R1 idle";  run(3, 1'b0);
    cur_tag = "R8 setup"; wr(0, 9); wr(1, 3); wr(2, 6); wr(3, 8);
    cur_tag = "R4 R5 mixed polarity"; run(40, 1'b1);
    cur_tag = "R2 gated count";
    for (int i = 0; i < 36; i++) step(i % 3 != 0, 1'b0, 0, 0);
    cur_tag = "R6 duty equals period"; wr(2, 9); run(30, 1'b1);
    cur_tag = "R7 duty above period";  wr(3, 20); run(30, 1'b1);
    cur_tag = "R3 zero period"; wr(0, 0); run(6, 1'b1);
    cur_tag = "R3 restore"; wr(0, 9); run(12, 1'b1);
    cur_tag = "R8 live write";
    step(1'b1, 1'b1, 0, 4); run(10, 1'b1);
    step(1'b1, 1'b1, NC + 1, 3'b010); run(12, 1'b1);
    cur_tag = "R8 unused address";
    step(1'b1, 1'b1, 5, 1); step(1'b1, 1'b1, 7, 0); run(12, 1'b1);
    cur_tag = "R9 wrap"; wr(0, 12);
    while (m_cnt != 8'd10) step(1'b1, 1'b0, 0, 0);
    step(1'b1, 1'b1, 0, 3); run(270, 1'b1);
    cur_tag = "R10 independent";
    wr(0, 9); wr(1, 2); wr(2, 5); wr(3, 7); wr(NC + 1, 3'b011);
    run(40, 1'b1);
    cur_tag = "R2 tail idle"; run(5, 1'b0);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule